// File: doc/BRIEF.md
# Prioritized UART Interrupt Status Logic

This block gathers every interrupt cause of one UART channel and turns them into a single encoded status word and an active-high interrupt line. Most causes are held in sticky flags: line errors, receive timeout, transmit holding register empty, the modem input change flags, the received flow-control and special characters, and the RTS and CTS changes. One cause is a live comparison: the receive FIFO fill level against the trigger level. An 8-bit enable word masks each cause. The status word always names the most urgent enabled cause.

Each flag is cleared by the host access that services it. A line status read clears the line error flag. A receive holding register read clears the timeout flag. A transmit holding register write clears the empty flag. A modem status read clears the modem change flags. A status read that reports the empty, character or flow level clears that level. The FIFOs, the timeout counter and the serial engine sit outside the block and deliver their events as inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Out of reset, no flag is set, isr_o reads 0x01 and irq_o is low while the enable word is zero.
- R2: Priority, highest first, with the isr_o code for each: line error 0x06, receive data ready 0x04, receive timeout 0x0C, transmit empty 0x02, modem change 0x00, flow/special character 0x10, RTS/CTS change 0x20. With nothing enabled and pending, the code is 0x01.
- R3: Receive data ready is pending while rx_level_i >= rx_trig_i and enable bit 0 is set. It drops as soon as the level falls below the trigger.
- R4: A pulse on rx_tmo_i sets a timeout flag, reported as 0x0C under enable bit 0. Data ready outranks it at the same level. Only a receive holding register read (rhr_rd_i) clears it.
- R5: A pulse on line_evt_i sets the line flag, reported as 0x06 under enable bit 2. Only lsr_rd_i clears it; a status read does not.
- R6: The transmit empty flag sets on the cycle after thr_empty_i rises. It also sets when enable bit 1 rises while thr_empty_i is high. It is reported as 0x02 under enable bit 1. It clears on thr_wr_i, or on isr_rd_i in a cycle where isr_o reads 0x02.
- R7: Each bit of msr_delta_o sets one cycle after its modem_i bit changes. The first cycle after reset only samples the inputs. Any set bit gives code 0x00 under enable bit 3. msr_rd_i clears all bits.
- R8: xoff_i sets a flag gated by enable bit 4, and spec_i sets a flag gated by enable bit 5. Both report 0x10. A status read that reports 0x10 clears whichever of the two is enabled.
- R9: rts_chg_i sets a flag gated by enable bit 6, and cts_chg_i sets a flag gated by enable bit 7. Both report 0x20. A status read that reports 0x20 clears whichever of the two is enabled.
- R10: A flag set while its enable is off is kept and is not reported. A status read that reports a different code leaves it unchanged.
- R11: irq_o is high exactly when some enabled cause is pending, that is, when isr_o is not 0x01.
- R12: When a set event and a clearing access hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien_i | input | 8 | Interrupt enable word |
| rx_level_i | input | CNT_W | Receive FIFO fill level |
| rx_trig_i | input | CNT_W | Receive trigger level |
| rx_tmo_i | input | 1 | Receive timeout event pulse |
| rhr_rd_i | input | 1 | Receive holding register read strobe |
| line_evt_i | input | 1 | Line error event pulse |
| lsr_rd_i | input | 1 | Line status read strobe |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| modem_i | input | MDM_N | Modem input levels |
| msr_rd_i | input | 1 | Modem status read strobe |
| xoff_i | input | 1 | Flow-control character received pulse |
| spec_i | input | 1 | Special character received pulse |
| rts_chg_i | input | 1 | RTS change event pulse |
| cts_chg_i | input | 1 | CTS change event pulse |
| isr_rd_i | input | 1 | Interrupt status read strobe |
| isr_o | output | 6 | Encoded highest-priority status |
| irq_o | output | 1 | Interrupt request, active high |
| msr_delta_o | output | MDM_N | Modem change flags |

## Verification
The sources are first raised one at a time, each with only its own enable set. This ties each code to its cause and to its own clearing access. All sources are then raised together and serviced in order. Each step must expose the next lower code, which tells a correct priority chain apart from a swapped pair. Masked sources, status reads that report another level, and set-with-clear in the same cycle show which flags survive accesses that must not touch them. The fill level is swept across the trigger, and modem inputs are toggled bit by bit, to pin the compare boundary and the edge detection.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ISR_W = 6;

    localparam logic [ISR_W-1:0] ISR_NONE = 6'h01;
    localparam logic [ISR_W-1:0] ISR_LINE = 6'h06;
    localparam logic [ISR_W-1:0] ISR_RXD  = 6'h04;
    localparam logic [ISR_W-1:0] ISR_TMO  = 6'h0C;
    localparam logic [ISR_W-1:0] ISR_THRE = 6'h02;
    localparam logic [ISR_W-1:0] ISR_MDM  = 6'h00;
    localparam logic [ISR_W-1:0] ISR_CHAR = 6'h10;
    localparam logic [ISR_W-1:0] ISR_FLOW = 6'h20;

    localparam int EN_RX   = 0;
    localparam int EN_THRE = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;
    localparam int EN_XOFF = 4;
    localparam int EN_SPEC = 5;
    localparam int EN_RTS  = 6;
    localparam int EN_CTS  = 7;

    typedef struct packed {
        logic line;
        logic tmo;
        logic thre;
        logic xoff;
        logic spec;
        logic rts;
        logic cts;
        logic thr_prev;
        logic en_thre_prev;
    } flag_state_t;

endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       ien_i,
    input  logic             thr_empty_i,
    input  logic             thr_wr_i,
    input  logic             line_evt_i,
    input  logic             lsr_rd_i,
    input  logic             tmo_evt_i,
    input  logic             rhr_rd_i,
    input  logic             xoff_evt_i,
    input  logic             spec_evt_i,
    input  logic             rts_evt_i,
    input  logic             cts_evt_i,
    input  logic             isr_rd_i,
    input  logic [ISR_W-1:0] isr_code_i,
    output flag_state_t      flags_o
);

    flag_state_t st_d, st_q;
    logic thre_set, rd_thre, rd_char, rd_flow;

    always_comb begin
        rd_thre  = isr_rd_i && (isr_code_i == ISR_THRE);
        rd_char  = isr_rd_i && (isr_code_i == ISR_CHAR);
        rd_flow  = isr_rd_i && (isr_code_i == ISR_FLOW);
        thre_set = (thr_empty_i && !st_q.thr_prev) ||
                   (thr_empty_i && ien_i[EN_THRE] && !st_q.en_thre_prev);

        st_d              = st_q;
        st_d.thr_prev     = thr_empty_i;
        st_d.en_thre_prev = ien_i[EN_THRE];
        st_d.line = line_evt_i || (st_q.line && !lsr_rd_i);
        st_d.tmo  = tmo_evt_i  || (st_q.tmo  && !rhr_rd_i);
        st_d.thre = thre_set   || (st_q.thre && !(thr_wr_i || rd_thre));
        st_d.xoff = xoff_evt_i || (st_q.xoff && !(rd_char && ien_i[EN_XOFF]));
        st_d.spec = spec_evt_i || (st_q.spec && !(rd_char && ien_i[EN_SPEC]));
        st_d.rts  = rts_evt_i  || (st_q.rts  && !(rd_flow && ien_i[EN_RTS]));
        st_d.cts  = cts_evt_i  || (st_q.cts  && !(rd_flow && ien_i[EN_CTS]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q;

    assert_line_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_evt_i |=> flags_o.line);
    assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o.line && !lsr_rd_i) |=> flags_o.line);
    assert_tmo_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_rd_i && !tmo_evt_i) |=> !flags_o.tmo);
    assert_thre_wr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_i && !thre_set) |=> !flags_o.thre);
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (xoff_evt_i && isr_rd_i) |=> flags_o.xoff);

endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem #(
    parameter int MDM_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MDM_N-1:0] modem_i,
    input  logic             msr_rd_i,
    output logic [MDM_N-1:0] delta_o
);

    typedef struct packed {
        logic [MDM_N-1:0] delta;
        logic [MDM_N-1:0] prev;
        logic             primed;
    } mdm_state_t;

    mdm_state_t st_d, st_q;
    logic [MDM_N-1:0] chg;

    always_comb begin
        chg         = st_q.primed ? (modem_i ^ st_q.prev) : '0;
        st_d        = st_q;
        st_d.prev   = modem_i;
        st_d.primed = 1'b1;
        for (int i = 0; i < MDM_N; i++) begin
            st_d.delta[i] = chg[i] || (st_q.delta[i] && !msr_rd_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign delta_o = st_q.delta;

    assert_msr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && chg == '0) |=> (delta_o == '0));
    assert_delta_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_rd_i |=> ((delta_o & $past(delta_o)) == $past(delta_o)));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [7:0]       ien_i,
    input  flag_state_t      flags_i,
    input  logic             rxd_lvl_i,
    input  logic             mdm_any_i,
    output logic [ISR_W-1:0] code_o,
    output logic             irq_o
);

    logic p_line, p_rxd, p_tmo, p_thre, p_mdm, p_char, p_flow;

    always_comb begin
        p_line = flags_i.line && ien_i[EN_LINE];
        p_rxd  = rxd_lvl_i    && ien_i[EN_RX];
        p_tmo  = flags_i.tmo  && ien_i[EN_RX];
        p_thre = flags_i.thre && ien_i[EN_THRE];
        p_mdm  = mdm_any_i    && ien_i[EN_MDM];
        p_char = (flags_i.xoff && ien_i[EN_XOFF]) || (flags_i.spec && ien_i[EN_SPEC]);
        p_flow = (flags_i.rts  && ien_i[EN_RTS])  || (flags_i.cts  && ien_i[EN_CTS]);

        if      (p_line) code_o = ISR_LINE;
        else if (p_rxd)  code_o = ISR_RXD;
        else if (p_tmo)  code_o = ISR_TMO;
        else if (p_thre) code_o = ISR_THRE;
        else if (p_mdm)  code_o = ISR_MDM;
        else if (p_char) code_o = ISR_CHAR;
        else if (p_flow) code_o = ISR_FLOW;
        else             code_o = ISR_NONE;

        irq_o = p_line | p_rxd | p_tmo | p_thre | p_mdm | p_char | p_flow;
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int MDM_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       ien_i,
    input  logic [CNT_W-1:0] rx_level_i,
    input  logic [CNT_W-1:0] rx_trig_i,
    input  logic             rx_tmo_i,
    input  logic             rhr_rd_i,
    input  logic             line_evt_i,
    input  logic             lsr_rd_i,
    input  logic             thr_empty_i,
    input  logic             thr_wr_i,
    input  logic [MDM_N-1:0] modem_i,
    input  logic             msr_rd_i,
    input  logic             xoff_i,
    input  logic             spec_i,
    input  logic             rts_chg_i,
    input  logic             cts_chg_i,
    input  logic             isr_rd_i,
    output logic [5:0]       isr_o,
    output logic             irq_o,
    output logic [MDM_N-1:0] msr_delta_o
);

    flag_state_t      flags;
    logic [ISR_W-1:0] code;
    logic             rxd_lvl;

    assign rxd_lvl = (rx_level_i >= rx_trig_i);

    uart_irq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ien_i      (ien_i),
        .thr_empty_i(thr_empty_i),
        .thr_wr_i   (thr_wr_i),
        .line_evt_i (line_evt_i),
        .lsr_rd_i   (lsr_rd_i),
        .tmo_evt_i  (rx_tmo_i),
        .rhr_rd_i   (rhr_rd_i),
        .xoff_evt_i (xoff_i),
        .spec_evt_i (spec_i),
        .rts_evt_i  (rts_chg_i),
        .cts_evt_i  (cts_chg_i),
        .isr_rd_i   (isr_rd_i),
        .isr_code_i (code),
        .flags_o    (flags)
    );

    uart_irq_modem #(.MDM_N(MDM_N)) u_modem (
        .clk     (clk),
        .rst_n   (rst_n),
        .modem_i (modem_i),
        .msr_rd_i(msr_rd_i),
        .delta_o (msr_delta_o)
    );

    uart_irq_prio u_prio (
        .ien_i    (ien_i),
        .flags_i  (flags),
        .rxd_lvl_i(rxd_lvl),
        .mdm_any_i(|msr_delta_o),
        .code_o   (code),
        .irq_o    (irq_o)
    );

    assign isr_o = code;

    assert_irq_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (isr_o != ISR_NONE));
    assert_line_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.line && ien_i[EN_LINE]) |-> (isr_o == ISR_LINE));
    assert_rxd_over_tmo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_lvl && ien_i[EN_RX] && !(flags.line && ien_i[EN_LINE])) |-> (isr_o == ISR_RXD));
    assert_idle_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_i == 8'h00) |-> (isr_o == ISR_NONE && !irq_o));

endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;

    localparam int CW = 7;
    localparam int MN = 4;

    logic clk = 0, rst_n = 0;
    logic [7:0] ien = 0;
    logic [CW-1:0] lvl = 0, trig = 8;
    logic tmo = 0, rhr = 0, lev = 0, lsr = 0, the = 0, twr = 0;
    logic [MN-1:0] mdm = 0;
    logic msr = 0, xo = 0, sp = 0, rc = 0, cc = 0, ird = 0;
    logic [5:0] isr;
    logic irq;
    logic [MN-1:0] dlt;

    int checks = 0, fails = 0, cyc = 0;
    string cur = "R1";

    // reference model state
    bit m_line, m_tmo, m_thre, m_xoff, m_spec, m_rts, m_cts, m_tprev, m_eprev, m_primed;
    bit [MN-1:0] m_prev, m_dlt;

    uart_irq_ctrl #(.CNT_W(CW), .MDM_N(MN)) u_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ien_i(ien), .rx_level_i(lvl), .rx_trig_i(trig),
        .rx_tmo_i(tmo), .rhr_rd_i(rhr), .line_evt_i(lev), .lsr_rd_i(lsr),
        .thr_empty_i(the), .thr_wr_i(twr), .modem_i(mdm), .msr_rd_i(msr),
        .xoff_i(xo), .spec_i(sp), .rts_chg_i(rc), .cts_chg_i(cc), .isr_rd_i(ird),
        .isr_o(isr), .irq_o(irq), .msr_delta_o(dlt));

    always #5 clk = ~clk;

    function automatic int exp_code();
        if (m_line && ien[2]) return 'h06;
        if (int'(lvl) >= int'(trig) && ien[0]) return 'h04;
        if (m_tmo && ien[0]) return 'h0C;
        if (m_thre && ien[1]) return 'h02;
        if (m_dlt != 0 && ien[3]) return 'h00;
        if ((m_xoff && ien[4]) || (m_spec && ien[5])) return 'h10;
        if ((m_rts && ien[6]) || (m_cts && ien[7])) return 'h20;
        return 'h01;
    endfunction

    always @(posedge clk) begin
        int c;
        c = exp_code();
        if (!rst_n) begin
            {m_line, m_tmo, m_thre, m_xoff, m_spec, m_rts, m_cts, m_tprev, m_eprev, m_primed} = '0;
            m_prev = 0; m_dlt = 0;
        end else begin
            if (lev) m_line = 1; else if (lsr) m_line = 0;
            if (tmo) m_tmo = 1; else if (rhr) m_tmo = 0;
            if ((the && !m_tprev) || (the && ien[1] && !m_eprev)) m_thre = 1;
            else if (twr || (ird && c == 'h02)) m_thre = 0;
            if (xo) m_xoff = 1; else if (ird && c == 'h10 && ien[4]) m_xoff = 0;
            if (sp) m_spec = 1; else if (ird && c == 'h10 && ien[5]) m_spec = 0;
            if (rc) m_rts = 1; else if (ird && c == 'h20 && ien[6]) m_rts = 0;
            if (cc) m_cts = 1; else if (ird && c == 'h20 && ien[7]) m_cts = 0;
            for (int i = 0; i < MN; i++) begin
                if (m_primed && mdm[i] != m_prev[i]) m_dlt[i] = 1;
                else if (msr) m_dlt[i] = 0;
            end
            m_tprev = the; m_eprev = ien[1]; m_prev = mdm; m_primed = 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            int e;
            e = exp_code();
            checks++;
            if (int'(isr) != e || irq != (e != 'h01) || dlt != m_dlt) begin
                fails++;
                $display("FAIL %s cycle %0d: isr=%h irq=%0b delta=%b expected isr=%h irq=%0b delta=%b",
                         cur, cyc, isr, irq, dlt, e, e != 'h01, m_dlt);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // directed check with a hand-computed value, sampled at the falling edge
    task automatic expect_isr(string tag, int code);
        @(negedge clk);
        checks++;
        if (int'(isr) != code || irq != (code != 'h01)) begin
            fails++;
            $display("FAIL %s: isr=%h irq=%0b expected isr=%h irq=%0b", tag, isr, irq, code, code != 'h01);
        end
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            checks++; fails++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        the = 1;
        // R1: reset state, everything masked
        cur = "R1";
        expect_isr("R1 reset idle", 'h01);
        expect_isr("R1 still idle", 'h01);

        // R6: empty flag set after reset, reported when enabled
        cur = "R6";
        ien = 8'h02; expect_isr("R6 thre reported", 'h02);
        ird = 1; tick(); ird = 0; expect_isr("R6 cleared by status read", 'h01);
        the = 0; tick(); the = 1; tick(); expect_isr("R6 set on rising empty", 'h02);
        twr = 1; tick(); twr = 0; expect_isr("R6 cleared by THR write", 'h01);
        ien = 0; tick(); ien = 8'h02; tick(); expect_isr("R6 enable rise while empty", 'h02);
        twr = 1; tick(); twr = 0; the = 0; tick();

        // R3: trigger level compare
        cur = "R3";
        ien = 8'h01; trig = 8; lvl = 7; tick(); expect_isr("R3 below trigger", 'h01);
        lvl = 8; tick(); expect_isr("R3 at trigger", 'h04);
        lvl = 9; tick(); expect_isr("R3 above trigger", 'h04);
        lvl = 3; tick(); expect_isr("R3 drops below", 'h01);

        // R4: timeout shares level with data ready
        cur = "R4";
        tmo = 1; tick(); tmo = 0; expect_isr("R4 timeout", 'h0C);
        lvl = 8; tick(); expect_isr("R4 data ready outranks timeout", 'h04);
        lvl = 0; tick(); expect_isr("R4 timeout remains", 'h0C);
        ird = 1; tick(); ird = 0; expect_isr("R4 status read keeps timeout", 'h0C);
        rhr = 1; tick(); rhr = 0; expect_isr("R4 cleared by RHR read", 'h01);

        // R5: line errors
        cur = "R5";
        ien = 8'h04; lev = 1; tick(); lev = 0; expect_isr("R5 line error", 'h06);
        ird = 1; tick(); ird = 0; expect_isr("R5 status read keeps line", 'h06);
        lsr = 1; tick(); lsr = 0; expect_isr("R5 cleared by LSR read", 'h01);

        // R7: modem changes
        cur = "R7";
        ien = 8'h08;
        for (int b = 0; b < MN; b++) begin
            mdm[b] = ~mdm[b]; tick(); expect_isr("R7 modem change", 'h00);
            msr = 1; tick(); msr = 0; expect_isr("R7 cleared by MSR read", 'h01);
        end
        mdm = 4'b1010; tick(); msr = 1; tick(); msr = 0; tick();

        // R8 / R9: character and flow flags
        cur = "R8";
        ien = 8'h10; xo = 1; tick(); xo = 0; expect_isr("R8 xoff", 'h10);
        ird = 1; tick(); ird = 0; expect_isr("R8 cleared by status read", 'h01);
        ien = 8'h20; sp = 1; tick(); sp = 0; expect_isr("R8 special char", 'h10);
        ird = 1; tick(); ird = 0; expect_isr("R8 special cleared", 'h01);
        cur = "R9";
        ien = 8'h40; rc = 1; tick(); rc = 0; expect_isr("R9 rts change", 'h20);
        ird = 1; tick(); ird = 0; expect_isr("R9 rts cleared", 'h01);
        ien = 8'h80; cc = 1; tick(); cc = 0; expect_isr("R9 cts change", 'h20);
        ird = 1; tick(); ird = 0; expect_isr("R9 cts cleared", 'h01);

        // R10: masked source retained, other-level reads leave it
        cur = "R10";
        ien = 8'h00; xo = 1; tick(); xo = 0; expect_isr("R10 masked xoff hidden", 'h01);
        ird = 1; tick(); ird = 0;
        ien = 8'h10; tick(); expect_isr("R10 xoff kept while masked", 'h10);
        ien = 8'h14; lev = 1; tick(); lev = 0; expect_isr("R10 line above xoff", 'h06);
        ird = 1; tick(); ird = 0; lsr = 1; tick(); lsr = 0;
        expect_isr("R10 xoff survives other-level read", 'h10);
        ird = 1; tick(); ird = 0; tick();

        // R12: set and clear in the same cycle
        cur = "R12";
        xo = 1; tick(); xo = 0; tick();
        xo = 1; ird = 1; tick(); xo = 0; ird = 0; expect_isr("R12 set wins", 'h10);
        ird = 1; tick(); ird = 0; tick();

        // R2 / R11: everything pending, serviced in priority order
        cur = "R2";
        ien = 8'hFF;
        lev = 1; tmo = 1; xo = 1; rc = 1; mdm[0] = ~mdm[0]; the = 1; lvl = 10;
        tick(); lev = 0; tmo = 0; xo = 0; rc = 0;
        expect_isr("R2 line first", 'h06);
        lsr = 1; tick(); lsr = 0; expect_isr("R2 data ready next", 'h04);
        lvl = 0; tick(); expect_isr("R2 timeout next", 'h0C);
        rhr = 1; tick(); rhr = 0; expect_isr("R2 thre next", 'h02);
        ird = 1; tick(); ird = 0; expect_isr("R2 modem next", 'h00);
        msr = 1; tick(); msr = 0; expect_isr("R2 char next", 'h10);
        ird = 1; tick(); ird = 0; expect_isr("R2 flow next", 'h20);
        cur = "R11";
        ird = 1; tick(); ird = 0; expect_isr("R11 idle, irq low", 'h01);
        tick(3);
        finish_run();
    end

endmodule